// File: doc/BRIEF.md
# Two-Layer Window Blend Compositor

This block merges one pixel position's worth of color from a background and two stacked layers into a single RGB888 output pixel. The caller presents the current screen coordinate, a valid strobe, and one ARGB8888 pixel per layer. Each layer also brings its own settings on dedicated ports: an enable, a color-key enable with a key color, a rectangular window, a constant alpha, a fallback ARGB color, and two 3-bit factor selects.

For each layer the block first decides what color that layer shows. Outside its window, or while it is disabled, a layer shows its fallback color. Inside, it shows the supplied pixel, which becomes fully transparent when keying is on and its RGB equals the key. The bottom layer is then blended over the background, and the upper layer is blended over that result. Each blend weights the layer color by a first factor and the color beneath by a second factor. Both factors are 8-bit fractions of 255, derived from the constant alpha and the pixel alpha. The output follows each valid input after a fixed three-cycle latency, with the strobe travelling beside the data.

Top module: `window_blend_compositor`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly three clock cycles earlier. An active-low reset clears `out_valid` and `out_rgb` to zero.
- R2: A layer's window is inclusive at both ends on each axis. A position is inside when hstart <= `pos_x` <= hstop and vstart <= `pos_y` <= vstop.
- R3: When a layer is disabled, or the position is outside its window, the layer's color and alpha are taken from its fallback ARGB word.
- R4: With key enable set, an in-window pixel of an enabled layer whose RGB bits 23:0 equal the 24-bit key (red 23:16, green 15:8, blue 7:0) is given alpha 0. The key is never compared against the fallback color.
- R5: The first factor uses code 3'b110 to select pixel alpha × constant alpha / 255. Every other code selects the constant alpha.
- R6: The second factor uses code 3'b111 to select 255 − (pixel alpha × constant alpha / 255). Every other code selects 255 − constant alpha.
- R7: Each output channel is min(255, q), where q = (t + (t >> 8)) >> 8, t = f1·C + f2·Cs + 128, C is the layer channel and Cs is the channel beneath.
- R8: Layer 0 is blended over the background, and layer 1 is blended over that result.
- R9: Pixel and fallback words are ARGB with alpha at 31:24, red at 23:16, green at 15:8 and blue at 7:0. The background and output are RGB with red at 23:16. Per-layer port vectors hold layer 0 in the least significant slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| pos_x | input | 12 | Current horizontal position |
| pos_y | input | 12 | Current vertical position |
| bg_rgb | input | 24 | Background RGB888 color |
| lay_en | input | 2 | Per-layer enable |
| lay_key_en | input | 2 | Per-layer color-key enable |
| lay_hstart | input | 24 | Per-layer first window column, 12 bits each |
| lay_hstop | input | 24 | Per-layer last window column |
| lay_vstart | input | 24 | Per-layer first window row |
| lay_vstop | input | 24 | Per-layer last window row |
| lay_key | input | 48 | Per-layer RGB key color |
| lay_calpha | input | 16 | Per-layer constant alpha |
| lay_dflt | input | 64 | Per-layer fallback ARGB color |
| lay_bf1 | input | 6 | Per-layer first-factor select |
| lay_bf2 | input | 6 | Per-layer second-factor select |
| lay_pix | input | 64 | Per-layer ARGB8888 pixel |
| out_valid | output | 1 | Output pixel strobe |
| out_rgb | output | 24 | Composited RGB888 pixel |

## Verification
The hardest case to reach from the ports is a blend whose weighted sum exceeds 255·255. That needs mixed factor codes, where a constant-alpha first factor is paired with a pixel-alpha second factor, so that f1 + f2 exceeds 255. The stimulus builds it from a layer with alpha-0 white, constant alpha 255 and codes 3'b100/3'b111. Layer ordering only shows when both windows overlap the same position and the two layers carry unequal alphas. One vector therefore places a half-transparent upper layer over an opaque black lower layer. Fallback-color keying is reached by programming the key equal to the fallback RGB while the layer is disabled.

// File: rtl/comp_pkg.sv
`timescale 1ns/1ps
package comp_pkg;
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;
  localparam int ARGB_W = 4 * CH_W;
  localparam int POS_W  = 12;
  localparam int CODE_W = 3;
  localparam int SUM_W  = 2 * CH_W + 2;

  localparam logic [CODE_W-1:0] F1_PIXMUL = 3'b110;
  localparam logic [CODE_W-1:0] F2_PIXMUL = 3'b111;

  typedef struct packed {
    logic [RGB_W-1:0] rgb;
    logic [CH_W-1:0]  f1;
    logic [CH_W-1:0]  f2;
  } blend_op_t;

  // rounded x/255 clipped to one channel
  function automatic logic [CH_W-1:0] div255_sat(input logic [SUM_W-1:0] x);
    logic [SUM_W-1:0] t;
    logic [SUM_W-1:0] q;
    t = x + SUM_W'(128);
    q = (t + (t >> 8)) >> 8;
    return (q > SUM_W'(255)) ? {CH_W{1'b1}} : q[CH_W-1:0];
  endfunction

  function automatic logic [CH_W-1:0] scale(input logic [CH_W-1:0] a, input logic [CH_W-1:0] b);
    return div255_sat(SUM_W'(a) * SUM_W'(b));
  endfunction

  function automatic logic [CH_W-1:0] blend_ch(input logic [CH_W-1:0] c,
                                               input logic [CH_W-1:0] cs,
                                               input logic [CH_W-1:0] f1,
                                               input logic [CH_W-1:0] f2);
    return div255_sat(SUM_W'(f1) * SUM_W'(c) + SUM_W'(f2) * SUM_W'(cs));
  endfunction

  function automatic logic in_span(input logic [POS_W-1:0] p,
                                   input logic [POS_W-1:0] lo,
                                   input logic [POS_W-1:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction
endpackage

// File: rtl/comp_layer_prep.sv
`timescale 1ns/1ps
module comp_layer_prep
  import comp_pkg::*;
(
  input  logic [POS_W-1:0]  pos_x,
  input  logic [POS_W-1:0]  pos_y,
  input  logic              en,
  input  logic              key_en,
  input  logic [POS_W-1:0]  hstart,
  input  logic [POS_W-1:0]  hstop,
  input  logic [POS_W-1:0]  vstart,
  input  logic [POS_W-1:0]  vstop,
  input  logic [RGB_W-1:0]  key,
  input  logic [CH_W-1:0]   calpha,
  input  logic [ARGB_W-1:0] dflt,
  input  logic [CODE_W-1:0] bf1,
  input  logic [CODE_W-1:0] bf2,
  input  logic [ARGB_W-1:0] pix,
  output blend_op_t         op,
  output logic              hit_win,
  output logic              key_hit
);
  logic              use_pix;
  logic [ARGB_W-1:0] src;
  logic [CH_W-1:0]   alpha;
  logic [CH_W-1:0]   pa_ca;

  assign hit_win = in_span(pos_x, hstart, hstop) && in_span(pos_y, vstart, vstop);
  assign use_pix = en && hit_win;
  assign key_hit = use_pix && key_en && (pix[RGB_W-1:0] == key);
  assign src     = use_pix ? pix : dflt;
  assign alpha   = key_hit ? '0 : src[ARGB_W-1:RGB_W];
  assign pa_ca   = scale(alpha, calpha);

  assign op.rgb = src[RGB_W-1:0];
  assign op.f1  = (bf1 == F1_PIXMUL) ? pa_ca : calpha;
  assign op.f2  = (bf2 == F2_PIXMUL) ? ~pa_ca : ~calpha;
endmodule

// File: rtl/comp_blend_stage.sv
`timescale 1ns/1ps
module comp_blend_stage
  import comp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_in,
  input  logic [RGB_W-1:0] acc_in,
  input  blend_op_t        op,
  output logic             vld_out,
  output logic [RGB_W-1:0] acc_out
);
  logic [RGB_W-1:0] nxt;

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      nxt[c*CH_W +: CH_W] = blend_ch(op.rgb[c*CH_W +: CH_W], acc_in[c*CH_W +: CH_W], op.f1, op.f2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_out <= 1'b0;
      acc_out <= '0;
    end else begin
      vld_out <= vld_in;
      acc_out <= nxt;
    end
  end
endmodule

// File: rtl/window_blend_compositor.sv
`timescale 1ns/1ps
module window_blend_compositor
  import comp_pkg::*;
#(
  parameter int NUM_LAYERS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [POS_W-1:0]             pos_x,
  input  logic [POS_W-1:0]             pos_y,
  input  logic [RGB_W-1:0]             bg_rgb,
  input  logic [NUM_LAYERS-1:0]        lay_en,
  input  logic [NUM_LAYERS-1:0]        lay_key_en,
  input  logic [NUM_LAYERS*POS_W-1:0]  lay_hstart,
  input  logic [NUM_LAYERS*POS_W-1:0]  lay_hstop,
  input  logic [NUM_LAYERS*POS_W-1:0]  lay_vstart,
  input  logic [NUM_LAYERS*POS_W-1:0]  lay_vstop,
  input  logic [NUM_LAYERS*RGB_W-1:0]  lay_key,
  input  logic [NUM_LAYERS*CH_W-1:0]   lay_calpha,
  input  logic [NUM_LAYERS*ARGB_W-1:0] lay_dflt,
  input  logic [NUM_LAYERS*CODE_W-1:0] lay_bf1,
  input  logic [NUM_LAYERS*CODE_W-1:0] lay_bf2,
  input  logic [NUM_LAYERS*ARGB_W-1:0] lay_pix,
  output logic                         out_valid,
  output logic [RGB_W-1:0]             out_rgb
);
  // named per-layer events, observed by the bound checker
  blend_op_t [NUM_LAYERS-1:0] op_c;
  blend_op_t [NUM_LAYERS-1:0] op_s0;
  logic [NUM_LAYERS-1:0]      hit_win_w;
  logic [NUM_LAYERS-1:0]      key_hit_w;

  logic                       vld_s0;
  logic [RGB_W-1:0]           bg_s0;
  logic [NUM_LAYERS:0]        vld;
  logic [NUM_LAYERS:0][RGB_W-1:0] acc;

  for (genvar gi = 0; gi < NUM_LAYERS; gi++) begin : g_prep
    comp_layer_prep u_prep (
      .pos_x   (pos_x),
      .pos_y   (pos_y),
      .en      (lay_en[gi]),
      .key_en  (lay_key_en[gi]),
      .hstart  (lay_hstart[gi*POS_W +: POS_W]),
      .hstop   (lay_hstop[gi*POS_W +: POS_W]),
      .vstart  (lay_vstart[gi*POS_W +: POS_W]),
      .vstop   (lay_vstop[gi*POS_W +: POS_W]),
      .key     (lay_key[gi*RGB_W +: RGB_W]),
      .calpha  (lay_calpha[gi*CH_W +: CH_W]),
      .dflt    (lay_dflt[gi*ARGB_W +: ARGB_W]),
      .bf1     (lay_bf1[gi*CODE_W +: CODE_W]),
      .bf2     (lay_bf2[gi*CODE_W +: CODE_W]),
      .pix     (lay_pix[gi*ARGB_W +: ARGB_W]),
      .op      (op_c[gi]),
      .hit_win (hit_win_w[gi]),
      .key_hit (key_hit_w[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s0 <= 1'b0;
      bg_s0  <= '0;
      op_s0  <= '0;
    end else begin
      vld_s0 <= in_valid;
      bg_s0  <= bg_rgb;
      op_s0  <= op_c;
    end
  end

  assign vld[0] = vld_s0;
  assign acc[0] = bg_s0;

  for (genvar gi = 0; gi < NUM_LAYERS; gi++) begin : g_stage
    blend_op_t cur_op;
    if (gi == 0) begin : g_nodly
      assign cur_op = op_s0[gi];
    end else begin : g_dly
      blend_op_t dq [gi];
      always_ff @(posedge clk) begin
        dq[0] <= op_s0[gi];
        for (int k = 1; k < gi; k++) dq[k] <= dq[k-1];
      end
      assign cur_op = dq[gi-1];
    end
    comp_blend_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (vld[gi]),
      .acc_in  (acc[gi]),
      .op      (cur_op),
      .vld_out (vld[gi+1]),
      .acc_out (acc[gi+1])
    );
  end

  assign out_valid = vld[NUM_LAYERS];
  assign out_rgb   = acc[NUM_LAYERS];
endmodule

// File: rtl/comp_chk.sv
`timescale 1ns/1ps
module comp_chk
  import comp_pkg::*;
#(
  parameter int NUM_LAYERS = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         out_valid,
  input logic [RGB_W-1:0]             out_rgb,
  input logic [RGB_W-1:0]             bg_rgb,
  input logic [NUM_LAYERS-1:0]        lay_en,
  input logic [NUM_LAYERS-1:0]        lay_key_en,
  input logic [NUM_LAYERS-1:0]        hit_win_w,
  input logic [NUM_LAYERS-1:0]        key_hit_w,
  input logic [NUM_LAYERS*CH_W-1:0]   lay_calpha,
  input logic [NUM_LAYERS*CODE_W-1:0] lay_bf1,
  input logic [NUM_LAYERS*CODE_W-1:0] lay_bf2,
  input logic [NUM_LAYERS*ARGB_W-1:0] lay_dflt,
  input blend_op_t [NUM_LAYERS-1:0]   op_c
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc <= '0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  // R1: strobe delayed by exactly three edges
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R7: all constant alphas zero leaves the background untouched
  assert_clear_alpha_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid && lay_calpha == '0, 3)) |-> (out_rgb == $past(bg_rgb, 3)));

  for (genvar gi = 0; gi < NUM_LAYERS; gi++) begin : g_lay
    // R3: fallback color outside the window or when disabled
    assert_dflt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(lay_en[gi] && hit_win_w[gi]) |-> (op_c[gi].rgb == lay_dflt[gi*ARGB_W +: RGB_W]));

    // R4: a key hit needs keying on and a live in-window pixel
    assert_key_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit_w[gi] |-> (lay_key_en[gi] && lay_en[gi] && hit_win_w[gi]));

    // R4: keyed pixel contributes nothing through the pixel-alpha factor
    assert_key_alpha_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit_w[gi] && lay_bf1[gi*CODE_W +: CODE_W] == 3'b110) |-> (op_c[gi].f1 == '0));

    // R5: with full constant alpha, pixel-alpha factor equals the fallback alpha
    assert_f1_pix_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(lay_en[gi] && hit_win_w[gi]) && lay_calpha[gi*CH_W +: CH_W] == 8'hFF &&
       lay_bf1[gi*CODE_W +: CODE_W] == 3'b110)
      |-> (op_c[gi].f1 == lay_dflt[gi*ARGB_W+RGB_W +: CH_W]));

    // R6: matching complement for the second factor
    assert_f2_pix_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(lay_en[gi] && hit_win_w[gi]) && lay_calpha[gi*CH_W +: CH_W] == 8'hFF &&
       lay_bf2[gi*CODE_W +: CODE_W] == 3'b111)
      |-> (op_c[gi].f2 == 8'hFF - lay_dflt[gi*ARGB_W+RGB_W +: CH_W]));
  end
endmodule

bind window_blend_compositor comp_chk #(.NUM_LAYERS(NUM_LAYERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_rgb    (out_rgb),
  .bg_rgb     (bg_rgb),
  .lay_en     (lay_en),
  .lay_key_en (lay_key_en),
  .hit_win_w  (hit_win_w),
  .key_hit_w  (key_hit_w),
  .lay_calpha (lay_calpha),
  .lay_bf1    (lay_bf1),
  .lay_bf2    (lay_bf2),
  .lay_dflt   (lay_dflt),
  .op_c       (op_c)
);

// File: tb/window_blend_compositor_tb.sv
`timescale 1ns/1ps
module window_blend_compositor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] pos_x = '0, pos_y = '0;
  logic [23:0] bg_rgb = 24'h102030;
  logic [1:0]  lay_en = '0, lay_key_en = '0;
  logic [23:0] lay_hstart = {12'd15, 12'd10};
  logic [23:0] lay_hstop  = {12'd30, 12'd20};
  logic [23:0] lay_vstart = {12'd5, 12'd5};
  logic [23:0] lay_vstop  = {12'd8, 12'd8};
  logic [47:0] lay_key    = {24'h0000FF, 24'h00FF00};
  logic [15:0] lay_calpha = '0;
  logic [63:0] lay_dflt   = '0;
  logic [5:0]  lay_bf1 = '0, lay_bf2 = '0;
  logic [63:0] lay_pix = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  window_blend_compositor u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos_x(pos_x), .pos_y(pos_y),
    .bg_rgb(bg_rgb), .lay_en(lay_en), .lay_key_en(lay_key_en),
    .lay_hstart(lay_hstart), .lay_hstop(lay_hstop), .lay_vstart(lay_vstart),
    .lay_vstop(lay_vstop), .lay_key(lay_key), .lay_calpha(lay_calpha),
    .lay_dflt(lay_dflt), .lay_bf1(lay_bf1), .lay_bf2(lay_bf2), .lay_pix(lay_pix),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  // s fields hold {first-factor code, second-factor code}
  typedef struct packed {
    logic [11:0] x;
    logic [11:0] y;
    logic [1:0]  en;
    logic [1:0]  ken;
    logic [31:0] p1;
    logic [5:0]  s1;
    logic [7:0]  c1;
    logic [31:0] p2;
    logic [5:0]  s2;
    logic [7:0]  c2;
    logic [23:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{12'd0,  12'd0, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'hFF112233, 6'o67, 8'hFF, 24'h102030, 4'd3}, // R3
    '{12'd12, 12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'hFF112233, 6'o67, 8'hFF, 24'hAABBCC, 4'd9}, // R9
    '{12'd16, 12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'hFF112233, 6'o67, 8'hFF, 24'h112233, 4'd8}, // R8
    '{12'd16, 12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00112233, 6'o67, 8'hFF, 24'hAABBCC, 4'd5}, // R5
    '{12'd12, 12'd6, 2'b11, 2'b11, 32'hFF00FF00, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h102030, 4'd4}, // R4
    '{12'd12, 12'd6, 2'b11, 2'b10, 32'hFF00FF00, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h00FF00, 4'd4}, // R4
    '{12'd12, 12'd6, 2'b10, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h102030, 4'd3}, // R3
    '{12'd10, 12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'hAABBCC, 4'd2}, // R2
    '{12'd20, 12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'hAABBCC, 4'd2}, // R2
    '{12'd21, 12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h102030, 4'd2}, // R2
    '{12'd9,  12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h102030, 4'd2}, // R2
    '{12'd12, 12'd4, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h102030, 4'd2}, // R2
    '{12'd12, 12'd8, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'hAABBCC, 4'd2}, // R2
    '{12'd12, 12'd6, 2'b11, 2'b11, 32'h80FF0000, 6'o67, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h881018, 4'd7}, // R7
    '{12'd12, 12'd6, 2'b11, 2'b11, 32'h00FFFFFF, 6'o45, 8'h40, 32'h00000000, 6'o67, 8'hFF, 24'h4C5864, 4'd5}, // R5
    '{12'd12, 12'd6, 2'b11, 2'b11, 32'h00FFFFFF, 6'o00, 8'h40, 32'h00000000, 6'o67, 8'hFF, 24'h4C5864, 4'd6}, // R6
    '{12'd12, 12'd6, 2'b11, 2'b11, 32'h00FFFFFF, 6'o47, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'hFFFFFF, 4'd7}, // R7
    '{12'd16, 12'd6, 2'b11, 2'b11, 32'hFF000000, 6'o67, 8'hFF, 32'h80FFFFFF, 6'o67, 8'hFF, 24'h808080, 4'd8}, // R8
    '{12'd16, 12'd6, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'hFF0000FF, 6'o67, 8'hFF, 24'hAABBCC, 4'd4}, // R4
    '{12'd16, 12'd9, 2'b11, 2'b11, 32'hFFAABBCC, 6'o67, 8'hFF, 32'hFF112233, 6'o67, 8'hFF, 24'h102030, 4'd2}, // R2
    '{12'd12, 12'd6, 2'b11, 2'b11, 32'h80FF0000, 6'o60, 8'hFF, 32'h00000000, 6'o67, 8'hFF, 24'h800000, 4'd6}  // R6
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    pos_x      = v.x;
    pos_y      = v.y;
    lay_en     = v.en;
    lay_key_en = v.ken;
    lay_pix    = {v.p2, v.p1};
    lay_calpha = {v.c2, v.c1};
    lay_bf1    = {v.s2[5:3], v.s1[5:3]};
    lay_bf2    = {v.s2[2:0], v.s1[2:0]};
  endtask

  // one isolated pixel, checked three edges later and idle afterwards
  task automatic run_one(input vec_t v, input string tag);
    @(negedge clk); drive(v);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " valid"}, {23'd0, out_valid}, 24'd1);
    check(tag, out_rgb, v.exp);
    @(negedge clk);
    check("R1 valid drop", {23'd0, out_valid}, 24'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {23'd0, out_valid}, 24'd0);
    check("R1 reset rgb", out_rgb, 24'd0);
    rst_n = 1'b1;

    // back-to-back stream through the table
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        check($sformatf("R1 stream valid v%0d", k-3), {23'd0, out_valid}, 24'd1);
        check($sformatf("R%0d vector %0d", VECS[k-3].req, k-3), out_rgb, VECS[k-3].exp);
      end
      if (k < NV) drive(VECS[k]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    check("R1 idle after stream", {23'd0, out_valid}, 24'd0);

    // R3: disabled layer shows its fallback color with fallback alpha
    lay_dflt = {32'h00000000, 32'hFF445566};
    v = VECS[6]; v.exp = 24'h445566;
    run_one(v, "R3 disabled fallback");
    // R3: enabled layer outside its window
    v = VECS[0]; v.exp = 24'h445566;
    run_one(v, "R3 outside fallback");
    // R4: key equal to fallback RGB does not make the fallback transparent
    lay_key = {24'h0000FF, 24'h445566};
    v = VECS[6]; v.exp = 24'h445566;
    run_one(v, "R4 fallback not keyed");
    lay_key  = {24'h0000FF, 24'h00FF00};
    lay_dflt = '0;

    // R1: valid gap preserved through the pipe
    @(negedge clk); drive(VECS[1]);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); drive(VECS[13]);
    @(negedge clk); in_valid = 1'b0;
    check("R1 gap first valid", {23'd0, out_valid}, 24'd1);
    check("R9 gap first rgb", out_rgb, VECS[1].exp);
    @(negedge clk);
    check("R1 gap hole", {23'd0, out_valid}, 24'd0);
    @(negedge clk);
    check("R1 gap second valid", {23'd0, out_valid}, 24'd1);
    check("R7 gap second rgb", out_rgb, VECS[13].exp);

    // R1: reset in flight clears the pipe
    @(negedge clk); drive(VECS[2]);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R1 midreset valid", {23'd0, out_valid}, 24'd0);
    check("R1 midreset rgb", out_rgb, 24'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after midreset", {23'd0, out_valid}, 24'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule